// File: doc/BRIEF.md
# Flash Command State Machine

This block interprets the qualified write events seen by a flash array and keeps track of what the device is currently doing. Commands arrive as address/data pairs. Each command starts with a two-write unlock prefix and ends with a command byte. The block moves between idle array reading, armed states that wait for a program address or an erase confirm, timed program and erase activity, an erase-suspended mode and a sticky error mode. Program and erase activity is timed by simple down-counters.

For every read, the block tells the read path whether that address should return array contents or status. It does this by comparing the read sector against the mode and against the sector whose erase is suspended. Each sector has a protection bit. A program or erase aimed at a protected sector is dropped after a short dummy busy period. A temporary-unprotect input lifts every protection bit while it is high, and the bits take effect again as soon as it falls. A supply-lockout input forces the idle mode and blocks all writes while it is high.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the mode output is 0 (array read) and the status-select output is 0 for every read sector.
- R2: The writes 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 give mode 1 (program armed). The next write, to an unprotected sector, gives mode 3 for exactly PGM_CYC cycles, then mode 0. Status-select is 1 for every sector during mode 3.
- R3: In mode 0, a second unlock write with the wrong address or data cancels the sequence, so a following command byte is not recognised. In mode 2, any write that breaks the sequence returns the mode to 0.
- R4: Unlock plus 0x80 gives mode 2 (erase armed). A second unlock plus 0x30 then gives mode 4 on the written sector for exactly ERS_CYC cycles, then mode 0.
- R5: Unlock plus 0xB0 during mode 4 gives mode 5 (suspended). The erase counter then holds. Status-select is 1 only for the suspended sector. Unlock plus 0x30 resumes erasing, and the total time spent in mode 4 stays ERS_CYC.
- R6: In mode 5, unlock plus 0xA0 gives mode 6. The next write gives mode 7 for PGM_CYC cycles, then mode 5.
- R7: The failure input during mode 3, 4 or 7 gives mode 8. Mode 8 selects status for every sector and ignores every write except data 0xF0, which returns the mode to 0.
- R8: A program or erase aimed at a sector whose protection bit is 1, with temporary unprotect low, gives mode 3 for only IGN_CYC cycles and never mode 4. The mode then returns to 0.
- R9: While temporary unprotect is high, a protected sector is programmed with the normal PGM_CYC timing. Once it falls, the same sector is handled as in R8 again.
- R10: Lockout high gives mode 0 at the next clock whatever the current mode, and all writes are ignored while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout_i | input | 1 | Supply lockout: forces idle mode, blocks writes |
| tmp_unprot_i | input | 1 | Temporary unprotect of all sectors |
| sect_prot_i | input | SECT_N | Protection bit per sector |
| algo_fail_i | input | 1 | Embedded algorithm failure report |
| wr_en_i | input | 1 | Qualified write event, one cycle |
| wr_addr_i | input | ADDR_W | Write address (command decode bits) |
| wr_data_i | input | 8 | Write data byte |
| wr_sect_i | input | SECT_W | Sector of the write address |
| rd_sect_i | input | SECT_W | Sector of the current read address |
| rd_status_o | output | 1 | 1: read returns status, 0: array data |
| mode_o | output | 4 | Current mode code (0..8) |

## Verification
The hardest state to reach from the ports is a program that completes inside an erase suspend, followed by a resume that still finishes the erase on time. Getting there takes an erase start, a three-write suspend partway through, a three-write program arm, a program write and a three-write resume. The bench runs this chain as a directed case. A monitor counts every cycle spent in each mode, so the frozen erase counter shows up as an exact total. Random sector reads during the suspension test the sector-selective status path.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

  typedef enum logic [3:0] {
    M_READ      = 4'd0,
    M_PGM_ARM   = 4'd1,
    M_ERS_ARM   = 4'd2,
    M_PGM_BUSY  = 4'd3,
    M_ERS_BUSY  = 4'd4,
    M_SUSP      = 4'd5,
    M_SUSP_ARM  = 4'd6,
    M_SPGM_BUSY = 4'd7,
    M_ERROR     = 4'd8
  } fcsm_mode_e;

  localparam logic [11:0] UNLK_ADDR1 = 12'h555;
  localparam logic [11:0] UNLK_ADDR2 = 12'h2AA;
  localparam logic [7:0]  UNLK_DATA1 = 8'hAA;
  localparam logic [7:0]  UNLK_DATA2 = 8'h55;

  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERS_SET = 8'h80;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/fcsm_unlock.sv
module fcsm_unlock
  import fcsm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              cmd_v_o,
  output logic              miss_o
);

  logic [1:0] stg_q, stg_d;
  logic       hit1, hit2;

  assign hit1 = (addr_i == ADDR_W'(UNLK_ADDR1)) && (data_i == UNLK_DATA1);
  assign hit2 = (addr_i == ADDR_W'(UNLK_ADDR2)) && (data_i == UNLK_DATA2);

  always_comb begin
    stg_d   = stg_q;
    cmd_v_o = 1'b0;
    miss_o  = 1'b0;
    if (!en_i) begin
      stg_d = 2'd0;
    end else if (wr_i) begin
      case (stg_q)
        2'd0: begin
          if (hit1) stg_d = 2'd1;
          else      miss_o = 1'b1;
        end
        2'd1: begin
          if (hit2) begin
            stg_d = 2'd2;
          end else begin
            stg_d  = 2'd0;
            miss_o = 1'b1;
          end
        end
        default: begin
          stg_d   = 2'd0;
          cmd_v_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'd0;
    else        stg_q <= stg_d;
  end

endmodule

// File: rtl/fcsm_timer.sv
module fcsm_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = run_i && !load_i && (cnt_q == '0);
  assign cnt_en = clr_i || load_i || (run_i && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else if (run_i)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fcsm_rd_sel.sv
module fcsm_rd_sel
  import fcsm_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  fcsm_mode_e        mode_i,
  input  logic [SECT_W-1:0] susp_sect_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  output logic              status_o
);

  always_comb begin
    case (mode_i)
      M_PGM_BUSY, M_ERS_BUSY, M_SPGM_BUSY, M_ERROR: status_o = 1'b1;
      M_SUSP, M_SUSP_ARM: status_o = (rd_sect_i == susp_sect_i);
      default: status_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcsm_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECT_N  = 8,
  parameter int PGM_CYC = 6,
  parameter int ERS_CYC = 24,
  parameter int IGN_CYC = 2,
  localparam int SECT_W = (SECT_N > 1) ? $clog2(SECT_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lockout_i,
  input  logic              tmp_unprot_i,
  input  logic [SECT_N-1:0] sect_prot_i,
  input  logic              algo_fail_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [SECT_W-1:0] wr_sect_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  output logic              rd_status_o,
  output logic [3:0]        mode_o
);

  localparam int MAX_CYC = (ERS_CYC > PGM_CYC) ?
                           ((ERS_CYC > IGN_CYC) ? ERS_CYC : IGN_CYC) :
                           ((PGM_CYC > IGN_CYC) ? PGM_CYC : IGN_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  fcsm_mode_e       mode_q, mode_d;
  logic [SECT_W-1:0] susp_sect_q, susp_sect_d;
  logic             wr_ok, trk_en, cmd_v, miss, tgt_prot;
  logic             pgm_load, pgm_run, pgm_done;
  logic             ers_load, ers_run, ers_done;
  logic [CNT_W-1:0] pgm_val, pgm_cnt, ers_cnt;

  assign wr_ok    = wr_en_i && !lockout_i;
  assign tgt_prot = sect_prot_i[wr_sect_i] && !tmp_unprot_i;
  assign pgm_run  = (mode_q == M_PGM_BUSY) || (mode_q == M_SPGM_BUSY);
  assign ers_run  = (mode_q == M_ERS_BUSY);

  fcsm_unlock #(.ADDR_W(ADDR_W)) unlock_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (trk_en && !lockout_i),
    .wr_i    (wr_ok),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .cmd_v_o (cmd_v),
    .miss_o  (miss)
  );

  fcsm_timer #(.CNT_W(CNT_W)) pgm_tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (lockout_i),
    .load_i     (pgm_load),
    .load_val_i (pgm_val),
    .run_i      (pgm_run),
    .done_o     (pgm_done),
    .cnt_o      (pgm_cnt)
  );

  fcsm_timer #(.CNT_W(CNT_W)) ers_tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (lockout_i),
    .load_i     (ers_load),
    .load_val_i (CNT_W'(ERS_CYC - 1)),
    .run_i      (ers_run),
    .done_o     (ers_done),
    .cnt_o      (ers_cnt)
  );

  always_comb begin
    mode_d      = mode_q;
    susp_sect_d = susp_sect_q;
    trk_en      = 1'b0;
    pgm_load    = 1'b0;
    pgm_val     = tgt_prot ? CNT_W'(IGN_CYC - 1) : CNT_W'(PGM_CYC - 1);
    ers_load    = 1'b0;
    case (mode_q)
      M_READ: begin
        trk_en = 1'b1;
        if (cmd_v && wr_data_i == CMD_PROGRAM)      mode_d = M_PGM_ARM;
        else if (cmd_v && wr_data_i == CMD_ERS_SET) mode_d = M_ERS_ARM;
      end
      M_PGM_ARM: begin
        if (wr_ok) begin
          pgm_load = 1'b1;
          mode_d   = M_PGM_BUSY;
        end
      end
      M_ERS_ARM: begin
        trk_en = 1'b1;
        if (miss) begin
          mode_d = M_READ;
        end else if (cmd_v) begin
          if (wr_data_i != CMD_CONFIRM) begin
            mode_d = M_READ;
          end else if (tgt_prot) begin
            pgm_load = 1'b1;
            mode_d   = M_PGM_BUSY;
          end else begin
            ers_load    = 1'b1;
            susp_sect_d = wr_sect_i;
            mode_d      = M_ERS_BUSY;
          end
        end
      end
      M_PGM_BUSY: begin
        if (algo_fail_i)   mode_d = M_ERROR;
        else if (pgm_done) mode_d = M_READ;
      end
      M_ERS_BUSY: begin
        trk_en = 1'b1;
        if (algo_fail_i)   mode_d = M_ERROR;
        else if (ers_done) mode_d = M_READ;
        else if (cmd_v && wr_data_i == CMD_SUSPEND) mode_d = M_SUSP;
      end
      M_SUSP: begin
        trk_en = 1'b1;
        if (cmd_v && wr_data_i == CMD_PROGRAM)      mode_d = M_SUSP_ARM;
        else if (cmd_v && wr_data_i == CMD_CONFIRM) mode_d = M_ERS_BUSY;
      end
      M_SUSP_ARM: begin
        if (wr_ok) begin
          pgm_load = 1'b1;
          mode_d   = M_SPGM_BUSY;
        end
      end
      M_SPGM_BUSY: begin
        if (algo_fail_i)   mode_d = M_ERROR;
        else if (pgm_done) mode_d = M_SUSP;
      end
      M_ERROR: begin
        if (wr_ok && wr_data_i == CMD_RESET) mode_d = M_READ;
      end
      default: mode_d = M_READ;
    endcase
    if (lockout_i) mode_d = M_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_READ;
      susp_sect_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (ers_load) susp_sect_q <= susp_sect_d;
    end
  end

  fcsm_rd_sel #(.SECT_W(SECT_W)) rd_sel_i (
    .mode_i      (mode_q),
    .susp_sect_i (susp_sect_q),
    .rd_sect_i   (rd_sect_i),
    .status_o    (rd_status_o)
  );

  assign mode_o = mode_q;

  AST_LOCKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_i |=> (mode_q == M_READ)); // R10

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ERROR && !lockout_i && !(wr_en_i && wr_data_i == CMD_RESET))
    |=> (mode_q == M_ERROR)); // R7

  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP && !lockout_i) |=> ($stable(ers_cnt) && $stable(pgm_cnt))); // R5

  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PGM_BUSY || mode_q == M_ERS_BUSY) |-> rd_status_o); // R2

  AST_PROT_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ERS_ARM && cmd_v && tgt_prot) |=> (mode_q != M_ERS_BUSY)); // R8

endmodule

// File: tb/flash_cmd_fsm_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;

  localparam int PGM_CYC = 6;
  localparam int ERS_CYC = 24;
  localparam int IGN_CYC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lockout, tmp_unprot, algo_fail, wr_en;
  logic [7:0] sect_prot;
  logic [11:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] wr_sect, rd_sect;
  logic       rd_status;
  logic [3:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt [0:15];
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_fsm #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .IGN_CYC(IGN_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .lockout_i(lockout), .tmp_unprot_i(tmp_unprot),
    .sect_prot_i(sect_prot), .algo_fail_i(algo_fail), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_sect_i(wr_sect),
    .rd_sect_i(rd_sect), .rd_status_o(rd_status), .mode_o(mode)
  );

  always @(negedge clk) mcnt[mode] <= mcnt[mode] + 1;

  function automatic bit exp_status(input int m, input int rs, input int ss);
    if (m == 3 || m == 4 || m == 7 || m == 8) return 1'b1;
    if (m == 5 || m == 6) return (rs == ss);
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 16; i++) mcnt[i] = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [2:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_sect = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d, input logic [2:0] s);
    wr(12'h555, 8'hAA, 3'd0);
    wr(12'h2AA, 8'h55, 3'd0);
    wr(12'h555, d, s);
  endtask

  task automatic wait_leave(input int m);
    for (int i = 0; i < 500; i++) begin
      if (mode != m) break;
      @(negedge clk);
    end
  endtask

  task automatic prog(input logic [2:0] s);
    cmd(8'hA0, 3'd0);
    wr(12'h100, 8'h3C, s);
    wait_leave(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h1F2E3D);
    rst_n = 1'b0; lockout = 0; tmp_unprot = 0; algo_fail = 0; wr_en = 0;
    sect_prot = 8'b0001_0000; wr_addr = '0; wr_data = '0; wr_sect = '0; rd_sect = '0;
    clr_cnt();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    for (int s = 0; s < 8; s++) begin
      rd_sect = 3'(s); #0.1;
      chk(rd_status == 0, "R1 status", rd_status, 0);
    end

    // R2 program
    cmd(8'hA0, 3'd0);
    chk(mode == 1, "R2 armed", mode, 1);
    clr_cnt();
    wr(12'h123, 8'h5A, 3'd1);
    chk(mode == 3, "R2 busy", mode, 3);
    rd_sect = 3'($urandom_range(0, 7)); #0.1;
    chk(rd_status == exp_status(mode, rd_sect, 0), "R2 status", rd_status, 1);
    wait_leave(3);
    chk(mcnt[3] == PGM_CYC, "R2 duration", mcnt[3], PGM_CYC);
    chk(mode == 0, "R2 done", mode, 0);

    // R3 broken unlock
    wr(12'h555, 8'hAA, 3'd0);
    wr(12'h123, 8'h55, 3'd0);
    wr(12'h555, 8'hA0, 3'd0);
    chk(mode == 0, "R3 bad addr", mode, 0);
    wr(12'h555, 8'hAA, 3'd0);
    wr(12'h2AA, 8'h66, 3'd0);
    wr(12'h555, 8'h80, 3'd0);
    chk(mode == 0, "R3 bad data", mode, 0);
    cmd(8'h80, 3'd0);
    chk(mode == 2, "R3 erase armed", mode, 2);
    wr(12'h2AA, 8'hAA, 3'd0);
    chk(mode == 0, "R3 erase abort", mode, 0);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d == 8'hAA) d = 8'hAB;
      wr(12'($urandom), d, 3'($urandom));
      chk(mode == 0, "R3 random junk", mode, 0);
    end

    // R4 erase
    clr_cnt();
    cmd(8'h80, 3'd0);
    cmd(8'h30, 3'd2);
    chk(mode == 4, "R4 erasing", mode, 4);
    wait_leave(4);
    chk(mcnt[4] == ERS_CYC, "R4 duration", mcnt[4], ERS_CYC);
    chk(mode == 0, "R4 done", mode, 0);

    // R5 / R6 suspend with program inside
    clr_cnt();
    cmd(8'h80, 3'd0);
    cmd(8'h30, 3'd3);
    repeat (2) @(negedge clk);
    cmd(8'hB0, 3'd0);
    chk(mode == 5, "R5 suspended", mode, 5);
    for (int i = 0; i < 16; i++) begin
      rd_sect = (i < 2) ? 3'd3 : 3'($urandom_range(0, 7)); #0.1;
      chk(rd_status == exp_status(5, rd_sect, 3), "R5 sector status", rd_status,
          exp_status(5, rd_sect, 3));
    end
    repeat (10) @(negedge clk);
    chk(mode == 5, "R5 held", mode, 5);
    cmd(8'hA0, 3'd0);
    chk(mode == 6, "R6 armed", mode, 6);
    wr(12'h040, 8'h11, 3'd6);
    chk(mode == 7, "R6 busy", mode, 7);
    wait_leave(7);
    chk(mcnt[7] == PGM_CYC, "R6 duration", mcnt[7], PGM_CYC);
    chk(mode == 5, "R6 back to suspend", mode, 5);
    cmd(8'h30, 3'd0);
    chk(mode == 4, "R5 resumed", mode, 4);
    wait_leave(4);
    chk(mcnt[4] == ERS_CYC, "R5 total erase", mcnt[4], ERS_CYC);
    chk(mode == 0, "R5 done", mode, 0);

    // R7 failure
    cmd(8'hA0, 3'd0);
    wr(12'h010, 8'h22, 3'd1);
    @(negedge clk); algo_fail = 1'b1;
    @(negedge clk); algo_fail = 1'b0;
    chk(mode == 8, "R7 error", mode, 8);
    rd_sect = 3'd5; #0.1;
    chk(rd_status == 1, "R7 status", rd_status, 1);
    cmd(8'hA0, 3'd0);
    chk(mode == 8, "R7 sticky", mode, 8);
    wr(12'h000, 8'hF0, 3'd0);
    chk(mode == 0, "R7 reset", mode, 0);

    // R8 protected sector
    clr_cnt();
    prog(3'd4);
    chk(mcnt[3] == IGN_CYC, "R8 program ignored", mcnt[3], IGN_CYC);
    chk(mode == 0, "R8 after program", mode, 0);
    clr_cnt();
    cmd(8'h80, 3'd0);
    cmd(8'h30, 3'd4);
    wait_leave(3);
    chk(mcnt[4] == 0, "R8 no erase", mcnt[4], 0);
    chk(mcnt[3] == IGN_CYC, "R8 erase ignored", mcnt[3], IGN_CYC);
    chk(mode == 0, "R8 after erase", mode, 0);

    // R9 temporary unprotect
    tmp_unprot = 1'b1;
    clr_cnt();
    prog(3'd4);
    chk(mcnt[3] == PGM_CYC, "R9 unprotected", mcnt[3], PGM_CYC);
    tmp_unprot = 1'b0;
    clr_cnt();
    prog(3'd4);
    chk(mcnt[3] == IGN_CYC, "R9 reprotected", mcnt[3], IGN_CYC);

    // R10 lockout
    cmd(8'h80, 3'd0);
    cmd(8'h30, 3'd2);
    repeat (3) @(negedge clk);
    lockout = 1'b1;
    @(negedge clk);
    chk(mode == 0, "R10 forced idle", mode, 0);
    cmd(8'hA0, 3'd0);
    wr(12'h000, 8'h00, 3'd1);
    chk(mode == 0, "R10 writes ignored", mode, 0);
    lockout = 1'b0;
    @(negedge clk);
    chk(mode == 0, "R10 released", mode, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule